// File: doc/BRIEF.md
# PCM Sample-Rate and Buffer-Count Timer

This block holds two mode-2 down-counters that pace audio sample transfers. The rate counter divides a clock-enable input, `rate_tick`, into a sample-request strobe. The buffer counter counts completed transfers. When a block is finished it latches an end-of-buffer interrupt. A small write-only register bus programs both counters. The bus carries a shared mode byte, byte-wise count loads, gate bits, a PCM enable and a channel-width bit.

Software first writes the mode byte for a counter. It then waits out a short holdoff and loads the count low byte first, high byte second. Last, it sets the gate bits. For single-block transfers, software clears the PCM enable when the interrupt arrives. While the enable is clear, the buffer counter and the interrupt latch hold their state. Software then reloads the next block and sets the enable again.

The rate counter keeps only 8 bits of the 16-bit load. On a 16-bit transfer channel, the buffer counter steps once per two byte strobes.

Top module: `pcm_timer_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears:
  - the interrupt;
  - both counters' modes and counts;
  - the gate, PCM-enable and wide bits.
  
  After reset, `irq` and `xfer_req` are 0, and `rate_out_n` and `buf_out_n` are 1.
- R2: A write to address 2 is a mode byte. Bits 7:6 select the counter: 00 selects rate and 01 selects buffer. Bits 3:1 must equal 010 to program mode 2. A count write to a counter whose mode is not 2 has no effect. A mode write stops its counter until a full new count has been loaded.
- R3: A count write is dropped if it comes in any of the HOLD_CYC cycles that follow a mode write. The cycle right after the mode write is the first of these.
- R4: Count bytes go to address 0 (rate) or address 1 (buffer), low byte first. The first enabled tick after the high byte copies the value N into the counter. A terminal tick then follows every N enabled ticks, and a value of 0 means 2^width.
- R5: The rate counter keeps only the low byte. Its period is N mod 256, and a loaded 0 gives 256. The high byte completes the load but its value is dropped.
- R6: `xfer_req` is high for one cycle on each terminal tick of the rate counter while PCM enable is set.
- R7: Address 3 holds the control bits: bit 0 gates the rate counter and bit 1 gates the buffer counter. While a gate bit is 0, its counter holds its value.
- R8: The buffer counter ticks on `xfer_byte` only while its gate bit and PCM enable are both set. When the wide bit (address 3, bit 3) is 1, it ticks on every second such byte.
- R9: A terminal tick of the buffer counter sets `irq`. A loaded count of 1 never sets it.
- R10: Writing address 4 with bit 0 set clears `irq`. If a terminal event occurs in the same cycle, `irq` stays set.
- R11: While PCM enable (address 3, bit 2) is 0:
  - `xfer_req` stays low;
  - the buffer counter holds its value;
  - `irq` keeps its value unless it is acknowledged.
- R12: `buf_out_n` (and likewise `rate_out_n`) is low while its running counter holds the value 1, except when the loaded count is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| rate_tick | input | 1 | Clock enable that paces the rate counter |
| xfer_byte | input | 1 | One pulse per byte moved by the transfer engine |
| xfer_req | output | 1 | Sample transfer request strobe |
| irq | output | 1 | Latched end-of-buffer interrupt |
| rate_out_n | output | 1 | Rate counter mode-2 output, active low |
| buf_out_n | output | 1 | Buffer counter mode-2 output, active low |

## Verification
The assertions check a set of cycle-level rules on every cycle:
- a counter holds its value on any cycle without a tick;
- a terminal tick reloads the stored value;
- an unprogrammed counter keeps its reload;
- no count is accepted right after a mode write;
- a buffer terminal event always leaves `irq` set;
- `irq` holds while PCM enable is clear.

Only the bench scenarios can show the end-to-end effects. These are the measured divide periods, the loss of the high byte and the 0-means-256 case, holdoff rejection shifting the byte order, the two-byte stepping on wide channels, and the silence of a count of 1.

// File: rtl/pcm_tmr_pkg.sv
// Shared register addresses, mode codes and control-register layout for the
// PCM timer pair. Assumes an 8-bit write-only register bus.
package pcm_tmr_pkg;
    localparam logic [2:0] ADDR_CNT_RATE = 3'd0;
    localparam logic [2:0] ADDR_CNT_BUF  = 3'd1;
    localparam logic [2:0] ADDR_MODE     = 3'd2;
    localparam logic [2:0] ADDR_CTRL     = 3'd3;
    localparam logic [2:0] ADDR_ACK      = 3'd4;

    localparam logic [2:0] MODE_RATE_GEN = 3'b010;

    typedef struct packed {
        logic wide;
        logic pcm_en;
        logic gate_buf;
        logic gate_rate;
    } ctrl_t;
endpackage

// File: rtl/pcm_tmr_holdoff.sv
// Holdoff window after a mode write: busy stays high for HOLD_CYC cycles
// following the start pulse. Assumes HOLD_CYC >= 1.
module pcm_tmr_holdoff #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CYC);

    logic [HW-1:0] left_q;

    // Load the window on start, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (start)
            left_q <= HOLD_INIT;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    a_r3_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/pcm_tmr_counter.sv
// One mode-2 down-counter with byte-wise load (low then high). Keeps W bits
// of the loaded value; a count of 0 means 2^W. A loaded value of 1 never
// produces a terminal event. Assumes BYTE_W < W <= 2*BYTE_W or W <= BYTE_W.
module pcm_tmr_counter #(
    parameter int W      = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_ok,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    output logic              term,
    output logic              out_n
);
    localparam logic [W-1:0] ONE = W'(1);

    logic              armed_q, hi_next_q, pend_q, run_q;
    logic [BYTE_W-1:0] lo_q;
    logic [W-1:0]      reload_q, count_q, new_val;
    logic              at_one, reload_one, live;

    // Assemble the value kept from the two load bytes.
    generate
        if (W > BYTE_W) begin : g_two_byte
            assign new_val = {wdata[W-BYTE_W-1:0], lo_q};
        end else begin : g_one_byte
            assign new_val = lo_q[W-1:0];
        end
    endgenerate

    assign at_one     = (count_q == ONE);
    assign reload_one = (reload_q == ONE);
    assign live       = run_q && !pend_q && !reload_one;

    // Mode arming, byte sequencing and pending-load control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            hi_next_q <= 1'b0;
            pend_q    <= 1'b0;
            run_q     <= 1'b0;
            lo_q      <= '0;
            reload_q  <= '0;
        end else if (mode_wr) begin
            armed_q   <= mode_ok;
            hi_next_q <= 1'b0;
            pend_q    <= 1'b0;
            run_q     <= 1'b0;
        end else begin
            if (tick && pend_q) begin
                run_q  <= 1'b1;
                pend_q <= 1'b0;
            end
            if (data_wr && armed_q) begin
                if (!hi_next_q) begin
                    lo_q      <= wdata;
                    hi_next_q <= 1'b1;
                end else begin
                    reload_q  <= new_val;
                    hi_next_q <= 1'b0;
                    pend_q    <= 1'b1;
                end
            end
        end
    end

    // Count register: load on first tick, then decrement with reload at 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (tick && pend_q)
            count_q <= reload_q;
        else if (tick && run_q)
            count_q <= at_one ? reload_q : count_q - 1'b1;
    end

    assign term  = tick && live && at_one;
    assign out_n = !(live && at_one);

    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));
    a_r4_reload_on_term: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (count_q == $past(reload_q)));
    a_r2_unarmed_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !mode_wr) |=> $stable(reload_q));
endmodule

// File: rtl/pcm_tmr_irq.sv
// End-of-buffer interrupt latch: set wins over clear in the same cycle.
module pcm_tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    // Latch terminal events, clear on acknowledge unless an event coincides.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set)
            irq <= 1'b1;
        else if (clr)
            irq <= 1'b0;
    end

    a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set));
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
endmodule

// File: rtl/pcm_timer_pair.sv
// Top of the PCM timer pair: register decode, gate/enable control, channel
// width stepping and the two mode-2 counters. Assumes a single write per
// cycle and single-cycle rate_tick / xfer_byte pulses from their sources.
module pcm_timer_pair
    import pcm_tmr_pkg::*;
#(
    parameter int RATE_W   = 8,
    parameter int BUF_W    = 16,
    parameter int HOLD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       rate_tick,
    input  logic       xfer_byte,
    output logic       xfer_req,
    output logic       irq,
    output logic       rate_out_n,
    output logic       buf_out_n
);
    localparam int NCNT = 2;

    ctrl_t            ctrl_q;
    logic             phase_q;
    logic             mode_any, mode_ok, hold_busy, cnt_acc, ack_hit, byte_ok;
    logic [NCNT-1:0]  mode_sel, data_sel, tick, term, out_n;

    assign mode_any = bus_wr && (bus_addr == ADDR_MODE);
    assign mode_ok  = (bus_wdata[3:1] == MODE_RATE_GEN);
    assign cnt_acc  = bus_wr && !hold_busy &&
                      ((bus_addr == ADDR_CNT_RATE) || (bus_addr == ADDR_CNT_BUF));
    assign ack_hit  = bus_wr && (bus_addr == ADDR_ACK) && bus_wdata[0];
    assign byte_ok  = xfer_byte && ctrl_q.gate_buf && ctrl_q.pcm_en;

    assign tick[0] = rate_tick && ctrl_q.gate_rate;
    assign tick[1] = byte_ok && (!ctrl_q.wide || phase_q);

    // Control register holding gates, PCM enable and channel width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && (bus_addr == ADDR_CTRL))
            ctrl_q <= ctrl_t'(bus_wdata[3:0]);
    end

    // Byte phase for wide channels: the buffer counter steps on odd bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (mode_sel[1])
            phase_q <= 1'b0;
        else if (byte_ok && ctrl_q.wide)
            phase_q <= !phase_q;
    end

    pcm_tmr_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mode_any),
        .busy  (hold_busy)
    );

    generate
        for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
            localparam int CW = (gi == 0) ? RATE_W : BUF_W;
            assign mode_sel[gi] = mode_any && (bus_wdata[7:6] == 2'(gi));
            assign data_sel[gi] = cnt_acc && (bus_addr == 3'(gi));
            pcm_tmr_counter #(.W(CW), .BYTE_W(8)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .mode_wr (mode_sel[gi]),
                .mode_ok (mode_ok),
                .data_wr (data_sel[gi]),
                .wdata   (bus_wdata),
                .tick    (tick[gi]),
                .term    (term[gi]),
                .out_n   (out_n[gi])
            );
        end
    endgenerate

    pcm_tmr_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (term[1]),
        .clr   (ack_hit),
        .irq   (irq)
    );

    assign xfer_req   = term[0] && ctrl_q.pcm_en;
    assign rate_out_n = out_n[0];
    assign buf_out_n  = out_n[1];

    a_r3_no_load_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_acc |-> !$past(mode_any));
    a_r11_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.pcm_en && !ack_hit) |=> $stable(irq));
    a_r8_no_tick_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.pcm_en || !ctrl_q.gate_buf) |-> (tick[1] == 1'b0));
endmodule

// File: tb/sim_pcm_timer_pair.sv
module sim_pcm_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       rate_tick = 1'b0;
    logic       xfer_byte = 1'b0;
    logic       xfer_req, irq, rate_out_n, buf_out_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // {low byte, high byte, expected period}
    localparam logic [31:0] VEC [5] = '{
        {8'h05, 8'h00, 16'd5},
        {8'h0A, 8'h12, 16'd10},
        {8'h00, 8'h00, 16'd256},
        {8'h02, 8'h7F, 16'd2},
        {8'h40, 8'hFF, 16'd64}
    };

    pcm_timer_pair u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rate_tick(rate_tick), .xfer_byte(xfer_byte),
        .xfer_req(xfer_req), .irq(irq), .rate_out_n(rate_out_n),
        .buf_out_n(buf_out_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic byte_pulse();
        xfer_byte = 1'b1;
        @(negedge clk);
        xfer_byte = 1'b0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) byte_pulse();
    endtask

    task automatic load_buf(input logic [15:0] n);
        wr(3'd2, 8'h74);
        idle(6);
        wr(3'd1, n[7:0]);
        wr(3'd1, n[15:8]);
    endtask

    task automatic count_req(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (xfer_req) pulses++;
        end
    endtask

    task automatic measure(output int p);
        int t;
        t = 0;
        p = -1;
        while (!xfer_req && t < 2000) begin @(negedge clk); t++; end
        if (xfer_req) begin
            p = 0;
            t = 0;
            do begin @(negedge clk); p++; t++; end while (!xfer_req && t < 2000);
            if (!xfer_req) p = -1;
        end
    endtask

    initial begin
        int p;
        idle(3);
        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 xfer_req", xfer_req, 0);
        chk("R1 rate_out_n", rate_out_n, 1);
        chk("R1 buf_out_n", buf_out_n, 1);
        rst_n = 1'b1;
        idle(1);

        // R2: count load with no mode, then with a wrong mode code
        wr(3'd3, 8'h05);
        rate_tick = 1'b1;
        wr(3'd0, 8'h03);
        wr(3'd0, 8'h00);
        count_req(50, p);
        chk("R2 no mode", p, 0);
        wr(3'd2, 8'h36);
        idle(6);
        wr(3'd0, 8'h03);
        wr(3'd0, 8'h00);
        count_req(50, p);
        chk("R2 bad mode", p, 0);

        // R4 R5 R6: rate counter divide table
        for (int v = 0; v < 5; v++) begin
            wr(3'd2, 8'h34);
            idle(6);
            wr(3'd0, VEC[v][31:24]);
            wr(3'd0, VEC[v][23:16]);
            measure(p);
            chk("R5 R6 rate period", p, int'(VEC[v][15:0]));
        end

        // R3: write inside the holdoff is dropped
        wr(3'd2, 8'h34);
        wr(3'd0, 8'h03);
        idle(6);
        wr(3'd0, 8'h06);
        wr(3'd0, 8'h00);
        measure(p);
        chk("R3 holdoff", p, 6);

        // R11: no requests while PCM enable is clear
        wr(3'd3, 8'h01);
        count_req(300, p);
        chk("R11 no xfer_req", p, 0);
        rate_tick = 1'b0;

        // R4 R8 R9 R10: buffer counter on 8-bit channel
        wr(3'd3, 8'h06);
        load_buf(16'd4);
        bytes(4);
        chk("R4 first tick loads", irq, 0);
        byte_pulse();
        chk("R9 irq set", irq, 1);
        wr(3'd4, 8'h01);
        chk("R10 ack clears", irq, 0);
        bytes(3);
        chk("R4 period", irq, 0);
        byte_pulse();
        chk("R4 period end", irq, 1);
        wr(3'd4, 8'h01);

        // R9: count of 1 never interrupts
        load_buf(16'd1);
        bytes(20);
        chk("R9 count one irq", irq, 0);
        chk("R12 count one out", buf_out_n, 1);

        // R8: wide channel steps every second byte
        wr(3'd3, 8'h0E);
        load_buf(16'd3);
        bytes(7);
        chk("R8 wide early", irq, 0);
        byte_pulse();
        chk("R8 wide end", irq, 1);
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h06);

        // R7 R12: gate freeze at count 1
        load_buf(16'd4);
        bytes(4);
        chk("R12 out low at one", buf_out_n, 0);
        chk("R7 no irq yet", irq, 0);
        wr(3'd3, 8'h04);
        bytes(10);
        chk("R7 frozen irq", irq, 0);
        chk("R7 frozen out", buf_out_n, 0);
        wr(3'd3, 8'h06);
        byte_pulse();
        chk("R7 resumes", irq, 1);

        // R11: PCM enable clear holds counter and irq
        wr(3'd3, 8'h02);
        bytes(20);
        chk("R11 irq held", irq, 1);
        wr(3'd3, 8'h06);
        wr(3'd4, 8'h01);
        chk("R10 ack", irq, 0);
        bytes(3);
        chk("R11 count held", buf_out_n, 0);
        chk("R11 count held irq", irq, 0);

        // R10: event and acknowledge in the same cycle
        byte_pulse();
        chk("R10 pre", irq, 1);
        bytes(3);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01; xfer_byte = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; xfer_byte = 1'b0;
        chk("R10 event wins", irq, 1);
        wr(3'd4, 8'h01);
        chk("R10 ack after", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule